// File: doc/BRIEF.md
# MSI Capability Register File

This block holds the message-signalled-interrupt capability structure that sits in a PCI device's configuration space. Configuration accesses reach it as an offset relative to the first byte of the capability, a length code of 1, 2 or 4 bytes, and write data packed little-endian. Each byte of a write is steered to its own register byte. There, a per-byte writable mask decides which bits change, so read-only fields hold their values no matter how a write is aligned. Reads are combinational from the offset and length inputs.

At reset the block fills in its fixed fields from parameters. These are the capability identifier, the next-capability pointer, the multiple-message-capable field derived from the vector count, the 64-bit capable flag and the per-vector-masking flag. The register placement follows from the addressing width. The interrupt dispatch logic reads the live enable bit, the multiple-message-enable field, the message address, the message data, the mask register and the pending register from dedicated outputs. It updates the pending register through set and clear vectors. On every write that touches a mask byte, the block flags the bytes written and gives the mask value before and after the write in the same cycle, so the dispatcher can release messages that were held while masked.

Top module: `msi_cap_regfile`

## Requirements
- R1: A write of length code 0 (1 byte), 1 (2 bytes) or 2/3 (4 bytes) at offset `b` puts `cfg_wdata[8i+7:8i]` into byte `b+i` for each byte `i` of the access; unaligned accesses are allowed.
- R2: Byte 0 reads 0x05 and byte 1 reads `NEXT_PTR`; writes to either have no effect.
- R3: In control byte 2, only bit 0 (enable) and bits 6:4 (multiple message enable) accept writes; bits 3:1 hold the multiple-message-capable value and bit 7 holds the 64-bit capable flag.
- R4: Control byte 3 ignores all writes; it reads 0x01 (per-vector masking always capable).
- R5: The multiple-message-capable field is the smallest n in 0..5 with 2^n at least `NUM_VEC` (5 vectors give 3, 32 give 5); a `NUM_VEC` outside 1..32 stops elaboration.
- R6: After reset, enable, multiple message enable, address, data, mask and pending are all zero.
- R7: A read returns the addressed bytes little-endian in the low bytes of `cfg_rdata`; bytes beyond the access length read as zero.
- R8: With 64-bit addressing, address is at 4..11, data at 12..13, mask at 16..19, pending at 20..23 (size 24); otherwise address at 4..7, data at 8..9, mask at 12..15, pending at 16..19 (size 20), and the upper address half reads zero.
- R9: The pending register ignores configuration writes; each cycle it becomes `(pending & ~pend_clr) | pend_set`, so set wins over clear.
- R10: Bytes at or beyond the capability size ignore writes and read as zero; the two bytes after message data are reserved, read as zero and ignore writes.
- R11: In a write cycle, `mask_byte_wr[k]` is 1 exactly when mask byte k is written, `mask_old` equals the current mask and `mask_new` equals the mask the next cycle will hold.
- R12: `msi_en`, `msi_mme`, `msi_addr`, `msi_data`, `msi_mask` and `msi_pend` follow the stored register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the current access |
| cfg_off | input | 5 | Byte offset inside the capability |
| cfg_len | input | 2 | Access length code: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| cfg_wdata | input | 32 | Write data, little-endian |
| cfg_rdata | output | 32 | Read data for `cfg_off`/`cfg_len`, little-endian |
| pend_set | input | 32 | Pending bits to set this cycle |
| pend_clr | input | 32 | Pending bits to clear this cycle |
| msi_en | output | 1 | Enable bit |
| msi_mme | output | 3 | Multiple message enable field |
| msi_addr | output | 64 | Message address |
| msi_data | output | 16 | Message data |
| msi_mask | output | 32 | Per-vector mask register |
| msi_pend | output | 32 | Per-vector pending register |
| mask_byte_wr | output | 4 | Mask bytes written in this cycle |
| mask_old | output | 32 | Mask value before this write |
| mask_new | output | 32 | Mask value after this write |

## Verification
The byte-steering path is driven with aligned full-word writes, single-byte writes into the middle of a register, and unaligned four-byte writes that straddle two registers. The straddling writes show whether lanes are shifted by the offset rather than taken from fixed word positions. Writes of all ones aimed at the identifier, control, reserved and pending bytes, and writes starting at or running past the end of the capability, separate a correct writable mask from one that leaks a read-only bit. A second instance with 32-bit addressing and 32 vectors shows whether the layout and the capable field follow the parameters. Set/clear collisions on the pending register and a two-byte write across mask bytes 1 and 2 cover the dispatch-side update and the mask report.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

  // Largest capability footprint (64-bit layout).
  localparam int unsigned CAP_MAX = 24;
  localparam logic [7:0]  CAP_ID  = 8'h05;

  typedef enum logic [2:0] {
    K_ID, K_NEXT, K_CTRL_LO, K_CTRL_HI, K_RW, K_PEND, K_RSVD
  } byte_kind_e;

  function automatic int unsigned cap_size(bit is64);
    return is64 ? 24 : 20;
  endfunction

  function automatic int unsigned data_base(bit is64);
    return is64 ? 12 : 8;
  endfunction

  function automatic int unsigned mask_base(bit is64);
    return is64 ? 16 : 12;
  endfunction

  function automatic int unsigned pend_base(bit is64);
    return is64 ? 20 : 16;
  endfunction

  // Smallest n in 0..5 with 2**n >= nvec.
  function automatic int unsigned mmc_of(int unsigned nvec);
    int unsigned n = 5;
    for (int k = 5; k >= 0; k--)
      if ((32'd1 << k) >= nvec) n = k;
    return n;
  endfunction

  function automatic byte_kind_e kind_of(int unsigned off, bit is64);
    if (off == 0)                         return K_ID;
    if (off == 1)                         return K_NEXT;
    if (off == 2)                         return K_CTRL_LO;
    if (off == 3)                         return K_CTRL_HI;
    if (off < data_base(is64) + 2)        return K_RW;
    if (off < mask_base(is64))            return K_RSVD;
    if (off < pend_base(is64))            return K_RW;
    if (off < cap_size(is64))             return K_PEND;
    return K_RSVD;
  endfunction

  // Bits a configuration write may change, per byte kind.
  function automatic logic [7:0] wmask_of(byte_kind_e k);
    case (k)
      K_CTRL_LO: return 8'h71;
      K_RW:      return 8'hFF;
      default:   return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/msi_cap_lanes.sv
module msi_cap_lanes #(
  parameter int unsigned LANES    = 4,
  parameter int unsigned IN_W     = 5,
  parameter int unsigned OFF_W    = 6,
  parameter int unsigned CAP_SIZE = 24
) (
  input  logic [IN_W-1:0]        base,
  input  logic [1:0]             len,
  output logic [LANES-1:0]       lane_ok,
  output logic [LANES*OFF_W-1:0] lane_off
);

  logic [2:0] nbytes;

  always_comb begin
    case (len)
      2'd0:    nbytes = 3'd1;
      2'd1:    nbytes = 3'd2;
      default: nbytes = 3'd4;
    endcase
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [OFF_W-1:0] off;
    assign off = OFF_W'(base) + OFF_W'(i);
    assign lane_off[i*OFF_W +: OFF_W] = off;
    assign lane_ok[i] = (3'(i) < nbytes) && (off < OFF_W'(CAP_SIZE));
  end

endmodule

// File: rtl/msi_cap_store.sv
module msi_cap_store
  import msi_cap_pkg::*;
#(
  parameter int unsigned NUM_VEC  = 5,
  parameter bit          ADDR64   = 1'b1,
  parameter logic [7:0]  NEXT_PTR = 8'h70,
  parameter int unsigned LANES    = 4,
  parameter int unsigned OFF_W    = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_wr,
  input  logic [LANES-1:0]       lane_ok,
  input  logic [LANES*OFF_W-1:0] lane_off,
  input  logic [LANES*8-1:0]     wdata,
  input  logic [31:0]            pend_set,
  input  logic [31:0]            pend_clr,
  output logic [CAP_MAX*8-1:0]   cap_q
);

  localparam int unsigned PEND_AT = pend_base(ADDR64);
  localparam logic [2:0]  MMC     = 3'(mmc_of(NUM_VEC));

  for (genvar j = 0; j < CAP_MAX; j++) begin : g_byte
    localparam byte_kind_e KIND = kind_of(j, ADDR64);
    localparam logic [7:0] WM   = wmask_of(KIND);
    localparam logic [7:0] RSTV =
      (KIND == K_ID)      ? CAP_ID :
      (KIND == K_NEXT)    ? NEXT_PTR :
      (KIND == K_CTRL_LO) ? {ADDR64, 3'b000, MMC, 1'b0} :
      (KIND == K_CTRL_HI) ? 8'h01 : 8'h00;

    logic [7:0] q, d;
    logic       en;

    if (KIND == K_PEND) begin : g_pend
      localparam int unsigned PB = j - PEND_AT;
      always_comb begin
        d  = (q & ~pend_clr[PB*8 +: 8]) | pend_set[PB*8 +: 8];
        en = (d != q);
      end
    end else begin : g_cfg
      logic       hit;
      logic [7:0] wbyte;
      always_comb begin
        hit   = 1'b0;
        wbyte = 8'h00;
        for (int i = 0; i < LANES; i++) begin
          if (cfg_wr && lane_ok[i] && lane_off[i*OFF_W +: OFF_W] == OFF_W'(j)) begin
            hit   = 1'b1;
            wbyte = wdata[i*8 +: 8];
          end
        end
        d  = (wbyte & WM) | (q & ~WM);
        en = hit && (WM != 8'h00);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RSTV;
      else if (en) q <= d;
    end

    assign cap_q[j*8 +: 8] = q;
  end

endmodule

// File: rtl/msi_cap_regfile.sv
module msi_cap_regfile
  import msi_cap_pkg::*;
#(
  parameter int unsigned NUM_VEC  = 5,
  parameter bit          ADDR64   = 1'b1,
  parameter logic [7:0]  NEXT_PTR = 8'h70
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [4:0]  cfg_off,
  input  logic [1:0]  cfg_len,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic [31:0] pend_set,
  input  logic [31:0] pend_clr,
  output logic        msi_en,
  output logic [2:0]  msi_mme,
  output logic [63:0] msi_addr,
  output logic [15:0] msi_data,
  output logic [31:0] msi_mask,
  output logic [31:0] msi_pend,
  output logic [3:0]  mask_byte_wr,
  output logic [31:0] mask_old,
  output logic [31:0] mask_new
);

  localparam int unsigned LANES   = 4;
  localparam int unsigned OFF_W   = 6;
  localparam int unsigned SIZE    = cap_size(ADDR64);
  localparam int unsigned DATA_AT = data_base(ADDR64);
  localparam int unsigned MASK_AT = mask_base(ADDR64);
  localparam int unsigned PEND_AT = pend_base(ADDR64);

  if (NUM_VEC < 1 || NUM_VEC > 32) begin : g_bad_nvec
    $error("msi_cap_regfile: NUM_VEC must lie in 1..32");
  end

  logic [LANES-1:0]       lane_ok;
  logic [LANES*OFF_W-1:0] lane_off;
  logic [CAP_MAX*8-1:0]   cap_q;

  msi_cap_lanes #(
    .LANES(LANES), .IN_W(5), .OFF_W(OFF_W), .CAP_SIZE(SIZE)
  ) u_lanes (
    .base(cfg_off), .len(cfg_len), .lane_ok(lane_ok), .lane_off(lane_off)
  );

  msi_cap_store #(
    .NUM_VEC(NUM_VEC), .ADDR64(ADDR64), .NEXT_PTR(NEXT_PTR),
    .LANES(LANES), .OFF_W(OFF_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr),
    .lane_ok(lane_ok), .lane_off(lane_off), .wdata(cfg_wdata),
    .pend_set(pend_set), .pend_clr(pend_clr), .cap_q(cap_q)
  );

  // Read mux: one byte per lane, zero for inactive lanes.
  for (genvar i = 0; i < LANES; i++) begin : g_rd
    logic [7:0] rbyte;
    always_comb begin
      rbyte = 8'h00;
      for (int j = 0; j < CAP_MAX; j++)
        if (lane_ok[i] && lane_off[i*OFF_W +: OFF_W] == OFF_W'(j))
          rbyte = cap_q[j*8 +: 8];
    end
    assign cfg_rdata[i*8 +: 8] = rbyte;
  end

  // Field views for the dispatcher.
  assign msi_en   = cap_q[2*8];
  assign msi_mme  = cap_q[2*8+4 +: 3];
  assign msi_data = cap_q[DATA_AT*8 +: 16];
  assign msi_mask = cap_q[MASK_AT*8 +: 32];
  assign msi_pend = cap_q[PEND_AT*8 +: 32];

  if (ADDR64) begin : g_a64
    assign msi_addr = cap_q[4*8 +: 64];
  end else begin : g_a32
    assign msi_addr = {32'h0, cap_q[4*8 +: 32]};
  end

  // Mask write report, per mask byte.
  assign mask_old = msi_mask;
  for (genvar k = 0; k < 4; k++) begin : g_mrep
    logic       hit;
    logic [7:0] nb;
    always_comb begin
      hit = 1'b0;
      nb  = msi_mask[k*8 +: 8];
      for (int i = 0; i < LANES; i++) begin
        if (cfg_wr && lane_ok[i] && lane_off[i*OFF_W +: OFF_W] == OFF_W'(MASK_AT + k)) begin
          hit = 1'b1;
          nb  = cfg_wdata[i*8 +: 8];
        end
      end
    end
    assign mask_byte_wr[k]   = hit;
    assign mask_new[k*8 +: 8] = nb;
  end

  // Assertions
  assert_id_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_off == 5'd0 && cfg_len == 2'd1) |-> cfg_rdata == {16'h0, NEXT_PTR, CAP_ID});

  assert_ctrl_ro_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(cap_q[2*8 +: 8] & 8'h8E));

  assert_ctrl_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(cap_q[3*8 +: 8]));

  assert_rd_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_len == 2'd0) |-> cfg_rdata[31:8] == 24'h0);

  assert_pend_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((msi_pend & ~$past(msi_pend)) & ~$past(pend_set)) == 32'h0);

  assert_oob_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && 32'(cfg_off) >= SIZE) |=>
      ($stable(msi_mask) && $stable(msi_addr) && $stable(msi_data) && $stable(msi_en)));

  assert_mask_rep_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_byte_wr != 4'h0) |=> msi_mask == $past(mask_new));

endmodule

// File: tb/test_msi_cap_regfile.sv
`timescale 1ns/1ps
module test_msi_cap_regfile;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int total = 0;
  int bad   = 0;

  // Instance A: 64-bit layout, 5 vectors, next pointer 0x70.
  logic        a_wr = 0;
  logic [4:0]  a_off = 0;
  logic [1:0]  a_len = 0;
  logic [31:0] a_wdata = 0, a_rdata;
  logic [31:0] a_pset = 0, a_pclr = 0;
  logic        a_en;
  logic [2:0]  a_mme;
  logic [63:0] a_addr;
  logic [15:0] a_data;
  logic [31:0] a_mask, a_pend, a_mold, a_mnew;
  logic [3:0]  a_mbw;

  msi_cap_regfile i_msi_cap_regfile (
    .clk(clk), .rst_n(rst_n), .cfg_wr(a_wr), .cfg_off(a_off), .cfg_len(a_len),
    .cfg_wdata(a_wdata), .cfg_rdata(a_rdata), .pend_set(a_pset), .pend_clr(a_pclr),
    .msi_en(a_en), .msi_mme(a_mme), .msi_addr(a_addr), .msi_data(a_data),
    .msi_mask(a_mask), .msi_pend(a_pend), .mask_byte_wr(a_mbw),
    .mask_old(a_mold), .mask_new(a_mnew)
  );

  // Instance B: 32-bit layout, 32 vectors, next pointer 0x00.
  logic        b_wr = 0;
  logic [4:0]  b_off = 0;
  logic [1:0]  b_len = 0;
  logic [31:0] b_wdata = 0, b_rdata;
  logic        b_en;
  logic [2:0]  b_mme;
  logic [63:0] b_addr;
  logic [15:0] b_data;
  logic [31:0] b_mask, b_pend, b_mold, b_mnew;
  logic [3:0]  b_mbw;

  msi_cap_regfile #(.NUM_VEC(32), .ADDR64(1'b0), .NEXT_PTR(8'h00)) i_msi_cap_regfile_b (
    .clk(clk), .rst_n(rst_n), .cfg_wr(b_wr), .cfg_off(b_off), .cfg_len(b_len),
    .cfg_wdata(b_wdata), .cfg_rdata(b_rdata), .pend_set(32'h0), .pend_clr(32'h0),
    .msi_en(b_en), .msi_mme(b_mme), .msi_addr(b_addr), .msi_data(b_data),
    .msi_mask(b_mask), .msi_pend(b_pend), .mask_byte_wr(b_mbw),
    .mask_old(b_mold), .mask_new(b_mnew)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_a(input logic [4:0] off, input logic [1:0] len, input logic [31:0] d);
    @(negedge clk);
    a_wr = 1'b1; a_off = off; a_len = len; a_wdata = d;
    @(negedge clk);
    a_wr = 1'b0;
  endtask

  task automatic rd_a(input logic [4:0] off, input logic [1:0] len, output logic [31:0] d);
    a_wr = 1'b0; a_off = off; a_len = len;
    #1;
    d = a_rdata;
  endtask

  task automatic wr_b(input logic [4:0] off, input logic [1:0] len, input logic [31:0] d);
    @(negedge clk);
    b_wr = 1'b1; b_off = off; b_len = len; b_wdata = d;
    @(negedge clk);
    b_wr = 1'b0;
  endtask

  task automatic rd_b(input logic [4:0] off, input logic [1:0] len, output logic [31:0] d);
    b_wr = 1'b0; b_off = off; b_len = len;
    #1;
    d = b_rdata;
  endtask

  // {wr, woff, wlen, wdata, roff, rlen, expected}; applied in order on instance A.
  localparam int NV = 12;
  localparam logic [78:0] VEC [NV] = '{
    {1'b1, 5'd0,  2'd2, 32'hFFFF_FFFF, 5'd0,  2'd2, 32'h01F7_7005}, // R2 R3 R4: only ctrl bits 0,6:4 take
    {1'b1, 5'd2,  2'd0, 32'h0000_0000, 5'd2,  2'd1, 32'h0000_0186}, // R3 clear writable ctrl bits
    {1'b1, 5'd4,  2'd2, 32'h1234_5678, 5'd4,  2'd2, 32'h1234_5678}, // R1 R8 address low
    {1'b1, 5'd8,  2'd2, 32'h9ABC_DEF0, 5'd4,  2'd1, 32'h0000_5678}, // R7 two-byte read
    {1'b1, 5'd12, 2'd2, 32'hAAAA_BEEF, 5'd12, 2'd2, 32'h0000_BEEF}, // R10 reserved after data
    {1'b1, 5'd16, 2'd1, 32'h0000_00FF, 5'd16, 2'd2, 32'h0000_00FF}, // R1 two-byte mask write
    {1'b1, 5'd18, 2'd0, 32'h0000_005A, 5'd16, 2'd2, 32'h005A_00FF}, // R1 single byte mid-register
    {1'b1, 5'd20, 2'd2, 32'hFFFF_FFFF, 5'd20, 2'd2, 32'h0000_0000}, // R9 pending ignores writes
    {1'b1, 5'd13, 2'd2, 32'h1122_3344, 5'd12, 2'd1, 32'h0000_44EF}, // R1 unaligned straddle
    {1'b0, 5'd0,  2'd0, 32'h0000_0000, 5'd16, 2'd0, 32'h0000_0011}, // R1 lane 3 reached mask
    {1'b1, 5'd24, 2'd2, 32'hFFFF_FFFF, 5'd22, 2'd2, 32'h0000_0000}, // R10 beyond size
    {1'b1, 5'd22, 2'd2, 32'hFFFF_FFFF, 5'd16, 2'd2, 32'h005A_0011}  // R10 R9 partial overrun
  };

  bit done = 0;

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    rd_a(5'd0, 2'd2, r);
    chk("R5 R2 reset ctrl/id A", 64'(r), 64'h01867005);
    chk("R6 reset en", 64'(a_en), 64'h0);
    chk("R6 reset mme", 64'(a_mme), 64'h0);
    chk("R6 reset addr", a_addr, 64'h0);
    chk("R6 reset mask", 64'(a_mask), 64'h0);
    chk("R6 reset pend", 64'(a_pend), 64'h0);
    rd_b(5'd0, 2'd2, r);
    chk("R5 R8 reset ctrl/id B", 64'(r), 64'h010A0005);

    // Vector table
    for (int n = 0; n < NV; n++) begin
      logic [78:0] v;
      v = VEC[n];
      if (v[78]) wr_a(v[77:73], v[72:71], v[70:39]);
      rd_a(v[38:34], v[33:32], r);
      chk($sformatf("R1/R7 table entry %0d", n), 64'(r), 64'(v[31:0]));
    end

    // Field outputs after table
    chk("R12 addr", a_addr, 64'h9ABCDEF0_12345678);
    chk("R12 data", 64'(a_data), 64'h44EF);
    chk("R12 mask", 64'(a_mask), 64'h005A0011);

    // Enable and mme outputs
    wr_a(5'd2, 2'd0, 32'h0000_0051);
    chk("R12 R3 en", 64'(a_en), 64'h1);
    chk("R12 R3 mme", 64'(a_mme), 64'h5);

    // Mask report: write bytes 17,18
    @(negedge clk);
    a_wr = 1'b1; a_off = 5'd17; a_len = 2'd1; a_wdata = 32'h0000_BBCC;
    #1;
    chk("R11 byte flags", 64'(a_mbw), 64'h6);
    chk("R11 old", 64'(a_mold), 64'h005A0011);
    chk("R11 new", 64'(a_mnew), 64'h00BBCC11);
    @(negedge clk);
    a_wr = 1'b0;
    chk("R11 mask after", 64'(a_mask), 64'h00BBCC11);
    #1;
    chk("R11 no flag without write", 64'(a_mbw), 64'h0);

    // Pending update
    a_pset = 32'h8;
    @(negedge clk);
    a_pset = 32'h0;
    chk("R9 set", 64'(a_pend), 64'h8);
    rd_a(5'd20, 2'd2, r);
    chk("R9 R7 read pending", 64'(r), 64'h8);
    a_pset = 32'h1; a_pclr = 32'h1;
    @(negedge clk);
    a_pset = 32'h0; a_pclr = 32'h0;
    chk("R9 set wins", 64'(a_pend), 64'h9);
    wr_a(5'd20, 2'd2, 32'h0);
    chk("R9 write ignored", 64'(a_pend), 64'h9);
    a_pclr = 32'hFFFF_FFFF;
    @(negedge clk);
    a_pclr = 32'h0;
    chk("R9 clear", 64'(a_pend), 64'h0);

    // ID and next pointer ignore a write
    wr_a(5'd0, 2'd1, 32'h0000_0000);
    rd_a(5'd0, 2'd1, r);
    chk("R2 id/next kept", 64'(r), 64'h7005);
    wr_a(5'd3, 2'd0, 32'h0000_00FE);
    rd_a(5'd3, 2'd0, r);
    chk("R4 ctrl hi kept", 64'(r), 64'h01);

    // Instance B: 32-bit layout
    wr_b(5'd4, 2'd2, 32'hCAFE_0001);
    chk("R8 addr 32-bit", b_addr, 64'h00000000_CAFE0001);
    wr_b(5'd8, 2'd2, 32'h7766_5544);
    rd_b(5'd8, 2'd2, r);
    chk("R8 R10 data 32-bit", 64'(r), 64'h5544);
    chk("R8 data out 32-bit", 64'(b_data), 64'h5544);
    wr_b(5'd12, 2'd2, 32'h0F0F_0F0F);
    chk("R8 mask 32-bit", 64'(b_mask), 64'h0F0F0F0F);
    rd_b(5'd16, 2'd2, r);
    chk("R8 pending 32-bit", 64'(r), 64'h0);
    wr_b(5'd20, 2'd2, 32'hFFFF_FFFF);
    rd_b(5'd18, 2'd2, r);
    chk("R10 beyond 32-bit size", 64'(r), 64'h0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule